// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an 8-bit-wide single-data-rate SDRAM from power-up to a programmed operating mode. After reset it keeps the command bus idle, with chip select, row strobe, column strobe and write enable all high. It holds the clock-enable pin low and drives the address and bank buses to zero. It then waits for a start request. The request starts a fixed timeline. Clock enable stays low for a first wait and then goes high. After a second, longer wait the block issues a precharge of all banks, then a train of auto-refresh commands, and then a mode register load that selects burst length 8, sequential bursts and CAS latency 2.

Every command occupies exactly one controller clock, and the command bus returns to the idle (inhibit) state in the next clock. Commands start a fixed number of clocks apart. After the mode register load the bus stays idle for a programmable tail. The block then raises a one-clock done pulse and stays parked until the next reset. The wait lengths, the command spacing and the refresh count are parameters counted in controller clocks. All outputs come from registers.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is asserted and afterwards until a start request is accepted, cmd_o is 4'b1111 (inhibit), cke_o is 0, addr_o is 0, ba_o is 0 and done_o is 0. An asynchronous reset in the middle of a sequence returns all of these outputs to these values at once.
- R2: If start_i is sampled high at clock edge P0 while the block is idle, cke_o stays 0 through edge P(CKE_LOW_CYC) and reads 1 from edge P(CKE_LOW_CYC+1). It then stays 1 until reset.
- R3: The first command is a precharge of all banks, cmd_o = {cs,ras,cas,we} = 4'b0010 with addr_o bit 10 set and all other address bits 0. It appears at edge P(CKE_LOW_CYC+CKE_HIGH_CYC+1), which is CKE_HIGH_CYC clocks after cke_o rises. No command appears while cke_o is 0.
- R4: REFRESH_CNT (default 8) auto-refresh commands follow, each cmd_o = 4'b0001 with addr_o = 0. Each command starts exactly CMD_GAP clocks after the previous one.
- R5: A mode register load follows, cmd_o = 4'b0000, CMD_GAP clocks after the last refresh. In that clock addr_o is 12'h023: bits [2:0] = 3 select burst 8, bit 3 = 0 selects sequential order, and bits [6:4] = 2 select CAS latency 2.
- R6: Every command lasts one clock. Every clock without a command, between commands and around them, shows cmd_o = 4'b1111. The pins cs_n_o, ras_n_o, cas_n_o and we_n_o equal cmd_o bits 3, 2, 1 and 0.
- R7: done_o is high for exactly one clock, TAIL_CYC+1 clocks after the mode register load, with inhibit on every clock between them. It never rises again before reset.
- R8: start_i is ignored while a sequence runs and after done. Whether start_i is pulsed again or held high, exactly one sequence runs per reset, and only a reset allows a new one.
- R9: ba_o is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock; the SDRAM clock runs at the same rate |
| rst_n | input | 1 | Asynchronous active-low reset; restarts the whole flow |
| start_i | input | 1 | Request to begin power-up; sampled only while idle |
| cke_o | output | 1 | SDRAM clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W | Address bus (A10 used for precharge-all, low bits carry the mode word) |
| ba_o | output | BANK_W | Bank select, held at zero |
| cmd_o | output | 4 | Current command as {cs,ras,cas,we} |
| done_o | output | 1 | One-clock pulse: device initialized |

## Verification
Every output sits one register stage behind the sequencing state. Each event is therefore due at a fixed edge counted from the edge P0 that accepted start. For CKE_LOW_CYC = L, CKE_HIGH_CYC = H, CMD_GAP = G and TAIL_CYC = T, with B = L+H+1:
- cke_o rises at P(L+1).
- The precharge appears at P(B).
- Refresh i (counting from 1) appears at P(B+i·G).
- The mode load appears at P(B+(REFRESH_CNT+1)·G).
- done_o rises T+1 edges after the mode load.
The bench samples the outputs on the falling edge after each counted rising edge and compares them with a table built from these offsets. Every sampled clock not listed in the table must show inhibit. Stray start pulses, start held high, and a reset in the middle of a sequence are each checked at the outputs, on the clocks where a second sequence or a stray command would appear.

// File: rtl/sdram_pwrup_pkg.sv
package sdram_pwrup_pkg;

   // Command code packed as {cs, ras, cas, we}, all active low on the pins.
   typedef enum logic [3:0] {
      CMD_LOADMODE = 4'b0000,
      CMD_REFRESH  = 4'b0001,
      CMD_PRE_ALL  = 4'b0010,
      CMD_INHIBIT  = 4'b1111
   } sdr_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CKE_LOW,
      ST_CKE_HIGH,
      ST_ISSUE,
      ST_SPACE,
      ST_TAIL,
      ST_FINISH,
      ST_HALT
   } seq_state_e;

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/sdram_pwrup_timer.sv
// Loadable down-counter: expired_o is high once the loaded count has run out.
module sdram_pwrup_timer #(
   parameter int TMR_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [TMR_W-1:0] value_i,
   output logic             expired_o
);

   logic [TMR_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= value_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/sdram_pwrup_fsm.sv
// Scripted power-up timeline: waits, then one command slot per step.
module sdram_pwrup_fsm
   import sdram_pwrup_pkg::*;
#(
   parameter int              ADDR_W       = 12,
   parameter int              CKE_LOW_CYC  = 500,
   parameter int              CKE_HIGH_CYC = 3000,
   parameter int              CMD_GAP      = 4,
   parameter int              TAIL_CYC     = 2,
   parameter int              REFRESH_CNT  = 8,
   parameter int              PRE_ALL_BIT  = 10,
   parameter logic [ADDR_W-1:0] MODE_WORD  = 'h023,
   parameter int              TMR_W        = 12,
   parameter int              STEP_W       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              expired_i,
   output logic              load_o,
   output logic [TMR_W-1:0]  value_o,
   output sdr_cmd_e          cmd_o,
   output logic              cke_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              done_o
);

   localparam int LAST_STEP = REFRESH_CNT + 1;

   seq_state_e        state_q, state_d;
   logic [STEP_W-1:0] step_q, step_d;
   logic              first_step, last_step;

   assign first_step = (step_q == '0);
   assign last_step  = (step_q == STEP_W'(LAST_STEP));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         step_q  <= '0;
      end else begin
         state_q <= state_d;
         step_q  <= step_d;
      end
   end

   always_comb begin
      state_d = state_q;
      step_d  = step_q;
      load_o  = 1'b0;
      value_o = '0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               state_d = ST_CKE_LOW;
               step_d  = '0;
               load_o  = 1'b1;
               value_o = TMR_W'(CKE_LOW_CYC - 1);
            end
         end
         ST_CKE_LOW: begin
            if (expired_i) begin
               state_d = ST_CKE_HIGH;
               load_o  = 1'b1;
               value_o = TMR_W'(CKE_HIGH_CYC - 1);
            end
         end
         ST_CKE_HIGH: begin
            if (expired_i) state_d = ST_ISSUE;
         end
         ST_ISSUE: begin
            load_o = 1'b1;
            if (last_step) begin
               state_d = ST_TAIL;
               value_o = TMR_W'(TAIL_CYC - 1);
            end else begin
               state_d = ST_SPACE;
               value_o = TMR_W'(CMD_GAP - 2);
            end
         end
         ST_SPACE: begin
            if (expired_i) begin
               state_d = ST_ISSUE;
               step_d  = step_q + 1'b1;
            end
         end
         ST_TAIL: begin
            if (expired_i) state_d = ST_FINISH;
         end
         ST_FINISH: state_d = ST_HALT;
         default:   state_d = ST_HALT;
      endcase
   end

   always_comb begin
      cmd_o  = CMD_INHIBIT;
      addr_o = '0;
      if (state_q == ST_ISSUE) begin
         if (first_step) begin
            cmd_o               = CMD_PRE_ALL;
            addr_o[PRE_ALL_BIT] = 1'b1;
         end else if (last_step) begin
            cmd_o  = CMD_LOADMODE;
            addr_o = MODE_WORD;
         end else begin
            cmd_o = CMD_REFRESH;
         end
      end
   end

   assign cke_o  = (state_q != ST_IDLE) && (state_q != ST_CKE_LOW);
   assign done_o = (state_q == ST_FINISH);

endmodule

// File: rtl/sdram_pwrup_pins.sv
// Output register stage: every pin leaves the block from a flop.
module sdram_pwrup_pins
   import sdram_pwrup_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int BANK_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sdr_cmd_e          cmd_i,
   input  logic              cke_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              done_i,
   output logic              cke_o,
   output logic              cs_n_o,
   output logic              ras_n_o,
   output logic              cas_n_o,
   output logic              we_n_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [BANK_W-1:0] ba_o,
   output logic [3:0]        cmd_o,
   output logic              done_o
);

   logic [3:0]        cmd_q;
   logic [ADDR_W-1:0] addr_q;
   logic              cke_q, done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= CMD_INHIBIT;
         addr_q <= '0;
         cke_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         cmd_q  <= cmd_i;
         addr_q <= addr_i;
         cke_q  <= cke_i;
         done_q <= done_i;
      end
   end

   // Pin order follows the {cs, ras, cas, we} packing of the command code.
   localparam int NPIN = 4;
   logic [NPIN-1:0] pin_n;
   for (genvar p = 0; p < NPIN; p++) begin : g_pin
      assign pin_n[p] = cmd_q[p];
   end

   assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = pin_n;
   assign cmd_o  = cmd_q;
   assign addr_o = addr_q;
   assign cke_o  = cke_q;
   assign done_o = done_q;
   assign ba_o   = '0;

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
   import sdram_pwrup_pkg::*;
#(
   parameter int ADDR_W       = 12,
   parameter int BANK_W       = 2,
   parameter int CKE_LOW_CYC  = 500,
   parameter int CKE_HIGH_CYC = 3000,
   parameter int CMD_GAP      = 4,
   parameter int TAIL_CYC     = 2,
   parameter int REFRESH_CNT  = 8,
   parameter int PRE_ALL_BIT  = 10,
   parameter int BURST_CODE   = 3,
   parameter int CAS_LAT      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              cke_o,
   output logic              cs_n_o,
   output logic              ras_n_o,
   output logic              cas_n_o,
   output logic              we_n_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [BANK_W-1:0] ba_o,
   output logic [3:0]        cmd_o,
   output logic              done_o
);

   localparam int MAX_WAIT = max4(CKE_LOW_CYC, CKE_HIGH_CYC, CMD_GAP, TAIL_CYC);
   localparam int TMR_W    = $clog2(MAX_WAIT + 1);
   localparam int STEP_W   = $clog2(REFRESH_CNT + 2);
   // Mode word: burst code in [2:0], sequential order (bit 3 = 0), latency in [6:4].
   localparam logic [ADDR_W-1:0] MODE_WORD =
      ADDR_W'(((CAS_LAT & 7) << 4) | (BURST_CODE & 7));

   logic              load;
   logic [TMR_W-1:0]  load_val;
   logic              expired;
   sdr_cmd_e          nxt_cmd;
   logic              nxt_cke, nxt_done;
   logic [ADDR_W-1:0] nxt_addr;

   sdram_pwrup_timer #(
      .TMR_W (TMR_W)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .value_i   (load_val),
      .expired_o (expired)
   );

   sdram_pwrup_fsm #(
      .ADDR_W       (ADDR_W),
      .CKE_LOW_CYC  (CKE_LOW_CYC),
      .CKE_HIGH_CYC (CKE_HIGH_CYC),
      .CMD_GAP      (CMD_GAP),
      .TAIL_CYC     (TAIL_CYC),
      .REFRESH_CNT  (REFRESH_CNT),
      .PRE_ALL_BIT  (PRE_ALL_BIT),
      .MODE_WORD    (MODE_WORD),
      .TMR_W        (TMR_W),
      .STEP_W       (STEP_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .expired_i (expired),
      .load_o    (load),
      .value_o   (load_val),
      .cmd_o     (nxt_cmd),
      .cke_o     (nxt_cke),
      .addr_o    (nxt_addr),
      .done_o    (nxt_done)
   );

   sdram_pwrup_pins #(
      .ADDR_W (ADDR_W),
      .BANK_W (BANK_W)
   ) u_pins (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd_i   (nxt_cmd),
      .cke_i   (nxt_cke),
      .addr_i  (nxt_addr),
      .done_i  (nxt_done),
      .cke_o   (cke_o),
      .cs_n_o  (cs_n_o),
      .ras_n_o (ras_n_o),
      .cas_n_o (cas_n_o),
      .we_n_o  (we_n_o),
      .addr_o  (addr_o),
      .ba_o    (ba_o),
      .cmd_o   (cmd_o),
      .done_o  (done_o)
   );

endmodule

// File: rtl/sdram_pwrup_chk.sv
module sdram_pwrup_chk #(
   parameter int                ADDR_W      = 12,
   parameter int                CMD_GAP     = 4,
   parameter int                TAIL_CYC    = 2,
   parameter int                REFRESH_CNT = 8,
   parameter int                PRE_ALL_BIT = 10,
   parameter logic [ADDR_W-1:0] MODE_WORD   = 'h023
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cke_o,
   input logic [ADDR_W-1:0] addr_o,
   input logic [3:0]        cmd_o,
   input logic              done_o
);

   localparam logic [3:0] C_INH = 4'b1111;
   localparam logic [3:0] C_PRE = 4'b0010;
   localparam logic [3:0] C_REF = 4'b0001;
   localparam logic [3:0] C_LMR = 4'b0000;
   localparam int SEEN_W = $clog2(REFRESH_CNT + 3);
   localparam int GAP_W  = $clog2(((CMD_GAP > TAIL_CYC) ? CMD_GAP : TAIL_CYC) + 2);

   logic [SEEN_W-1:0] seen_q;
   logic [GAP_W-1:0]  gap_q;
   logic              done_seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q      <= '0;
         gap_q       <= '0;
         done_seen_q <= 1'b0;
      end else begin
         if (cmd_o != C_INH) begin
            seen_q <= seen_q + 1'b1;
            gap_q  <= '0;
         end else if (gap_q != '1) begin
            gap_q <= gap_q + 1'b1;
         end
         if (done_o) done_seen_q <= 1'b1;
      end
   end

   p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cke_o |-> (cmd_o == C_INH && addr_o == '0 && !done_o));

   p_cke_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cke_o |=> cke_o);

   p_pre_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == C_PRE) |-> (seen_q == '0 && addr_o[PRE_ALL_BIT] && cke_o));

   p_ref_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == C_REF) |-> (seen_q >= SEEN_W'(1) && seen_q <= SEEN_W'(REFRESH_CNT)
                            && addr_o == '0));

   p_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o != C_INH && seen_q != '0) |-> (gap_q == GAP_W'(CMD_GAP - 1)));

   p_mode_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == C_LMR) |-> (seen_q == SEEN_W'(REFRESH_CNT + 1) && addr_o == MODE_WORD));

   p_one_clock_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o != C_INH) |=> (cmd_o == C_INH));

   p_done_tail_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (cmd_o == C_INH && seen_q == SEEN_W'(REFRESH_CNT + 2)
                  && gap_q == GAP_W'(TAIL_CYC) && !done_seen_q));

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_no_rerun_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q == SEEN_W'(REFRESH_CNT + 2)) |-> (cmd_o == C_INH));

endmodule

bind sdram_pwrup_seq sdram_pwrup_chk #(
   .ADDR_W      (ADDR_W),
   .CMD_GAP     (CMD_GAP),
   .TAIL_CYC    (TAIL_CYC),
   .REFRESH_CNT (REFRESH_CNT),
   .PRE_ALL_BIT (PRE_ALL_BIT),
   .MODE_WORD   (MODE_WORD)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .cke_o  (cke_o),
   .addr_o (addr_o),
   .cmd_o  (cmd_o),
   .done_o (done_o)
);

// File: tb/sdram_pwrup_seq_tb_top.sv
module sdram_pwrup_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int L = 5;
   localparam int H = 9;
   localparam int G = 4;
   localparam int T = 2;
   localparam int N = 8;
   localparam int BASE     = L + H + 1;
   localparam int LMR_OFF  = BASE + (N + 1) * G;
   localparam int DONE_OFF = LMR_OFF + 1 + T;
   localparam int END_OFF  = DONE_OFF + 4;
   localparam int NROWS    = N + 2;

   localparam logic [3:0] E_INH = 4'b1111;
   localparam logic [3:0] E_PRE = 4'b0010;
   localparam logic [3:0] E_REF = 4'b0001;
   localparam logic [3:0] E_LMR = 4'b0000;

   typedef struct packed {
      logic [15:0] off;
      logic [3:0]  cmd;
      logic [11:0] addr;
   } row_t;

   // Expected command timeline, offsets counted in edges from the start edge.
   localparam row_t ROWS [NROWS] = '{
      '{16'(BASE),         E_PRE, 12'h400},  // R3 precharge-all, A10 high
      '{16'(BASE + 1 * G), E_REF, 12'h000},  // R4 refresh 1
      '{16'(BASE + 2 * G), E_REF, 12'h000},  // R4
      '{16'(BASE + 3 * G), E_REF, 12'h000},  // R4
      '{16'(BASE + 4 * G), E_REF, 12'h000},  // R4
      '{16'(BASE + 5 * G), E_REF, 12'h000},  // R4
      '{16'(BASE + 6 * G), E_REF, 12'h000},  // R4
      '{16'(BASE + 7 * G), E_REF, 12'h000},  // R4
      '{16'(BASE + 8 * G), E_REF, 12'h000},  // R4 refresh 8
      '{16'(LMR_OFF),      E_LMR, 12'h023}   // R5 mode word
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, done_o;
   logic [11:0] addr_o;
   logic [1:0]  ba_o;
   logic [3:0]  cmd_o;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   sdram_pwrup_seq #(
      .ADDR_W       (12),
      .BANK_W       (2),
      .CKE_LOW_CYC  (L),
      .CKE_HIGH_CYC (H),
      .CMD_GAP      (G),
      .TAIL_CYC     (T),
      .REFRESH_CNT  (N)
   ) dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .cke_o   (cke_o),
      .cs_n_o  (cs_n_o),
      .ras_n_o (ras_n_o),
      .cas_n_o (cas_n_o),
      .we_n_o  (we_n_o),
      .addr_o  (addr_o),
      .ba_o    (ba_o),
      .cmd_o   (cmd_o),
      .done_o  (done_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic check_idle(input string req, input string what);
      check(cmd_o == E_INH && cke_o == 1'b0 && addr_o == '0 && ba_o == '0 && !done_o,
            req, what, {cmd_o, cke_o, addr_o, ba_o, done_o}, {E_INH, 16'h0});
   endtask

   // One full power-up run, sampled on the falling edge after each counted edge.
   task automatic run_seq(input bit hold_start, input bit poke);
      int row = 0;
      int gap_err = 0, cke_err = 0, done_err = 0, pin_err = 0, ba_err = 0;
      @(negedge clk);
      start_i = 1'b1;
      for (int k = 0; k <= END_OFF; k++) begin
         @(negedge clk);
         if (row < NROWS && int'(ROWS[row].off) == k) begin
            check(cmd_o == ROWS[row].cmd && addr_o == ROWS[row].addr,
                  (row == 0) ? "R3" : ((row == NROWS - 1) ? "R5" : "R4"),
                  $sformatf("command slot %0d at edge %0d", row, k),
                  {cmd_o, addr_o}, {ROWS[row].cmd, ROWS[row].addr});
            row++;
         end else if (cmd_o != E_INH || addr_o != '0) begin
            gap_err++;
         end
         if ({cs_n_o, ras_n_o, cas_n_o, we_n_o} != cmd_o) pin_err++;
         if (cke_o != (k >= L + 1)) cke_err++;
         if (done_o != (k == DONE_OFF)) done_err++;
         if (ba_o != '0) ba_err++;
         if (!hold_start)
            start_i = poke && (k == L + 2 || k == BASE + 1 || k == LMR_OFF);
      end
      start_i = 1'b0;
      check(row == NROWS, "R4", "all command slots reached", row, NROWS);
      check(gap_err == 0, "R6", "inhibit outside command slots", gap_err, 0);
      check(pin_err == 0, "R6", "pins match command vector", pin_err, 0);
      check(cke_err == 0, "R2", "cke low then high timing", cke_err, 0);
      check(done_err == 0, "R7", "single done pulse timing", done_err, 0);
      check(ba_err == 0, "R9", "bank bus zero", ba_err, 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : main
      int bad;
      // Reset state and idle wait (R1).
      repeat (3) @(negedge clk);
      check_idle("R1", "outputs during reset");
      rst_n = 1'b1;
      bad = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (cmd_o != E_INH || cke_o || addr_o != '0 || done_o) bad++;
      end
      check(bad == 0, "R1", "idle without start", bad, 0);

      // Main timeline with stray start pulses while running (R2..R8).
      run_seq(1'b0, 1'b1);

      // Start after done must not rerun (R8).
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      bad = 0;
      for (int i = 0; i < 80; i++) begin
         @(negedge clk);
         if (cmd_o != E_INH || !cke_o || done_o) bad++;
      end
      check(bad == 0, "R8", "start ignored after done", bad, 0);

      // Asynchronous reset in mid-sequence (R1).
      rst_n = 1'b0;
      #1;
      check_idle("R1", "reset after done");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (BASE + 2) @(negedge clk);
      check(cke_o == 1'b1, "R2", "cke high mid-run before reset", cke_o, 1);
      rst_n = 1'b0;
      #1;
      check_idle("R1", "async reset mid-sequence");
      @(negedge clk);
      check_idle("R1", "held in reset");
      rst_n = 1'b1;

      // Fresh run with start held high throughout (R8).
      run_seq(1'b1, 1'b0);
      bad = 0;
      start_i = 1'b1;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (cmd_o != E_INH || done_o) bad++;
      end
      start_i = 1'b0;
      check(bad == 0, "R8", "held start yields one sequence", bad, 0);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule